// File: doc/BRIEF.md
# Target Time Event and Rate Pulse Generator

This block watches the live time of a precision time counter, given as a seconds word and a binary subseconds word where one second equals 2^SUB_W subsecond units. Software loads a target time as two independently written words and may arm an interrupt. When the live time first reaches or passes the target, the block sets a sticky status flag. If the interrupt was armed, it also raises an interrupt line. Reading the status clears both. The interrupt arm is one-shot: it is consumed by the event it enables.

From the same time base the block derives a square-wave pulse output at 2^n Hz. The 0-based selector n picks the rate. Requests beyond the fastest rate the subseconds resolution allows are clamped to that rate. The time counter and the interrupt controller sit outside this block.

Top module: `ttc_event_pulse`

## Requirements
- R1: The target seconds word and the target subseconds word are loaded by separate write strobes, and a write to one leaves the other word unchanged.
- R2: The live time matches the target when the concatenation {seconds, subseconds} is greater than or equal to the target concatenation, compared as one unsigned number.
- R3: flag_o goes high on the clock edge that samples the first matching cycle after a non-matching one. It then stays high until read, and a live time that keeps matching does not set it again.
- R4: A cycle with stat_rd_i high and no new event clears flag_o and irq_o at that clock edge.
- R5: When a status read and a new event fall in the same cycle, flag_o stays set.
- R6: irq_o rises with flag_o only if the interrupt arm bit was set at the event. The event clears the arm bit, so a later event sets flag_o without irq_o unless software arms again. If an arm write and an event fall in the same cycle, the write wins.
- R7: With selector 0, pulse_o is high while the subseconds MSB is 0, which is the first half of each second. This gives a 1 Hz output.
- R8: With selector n from 1 to SUB_W-1, pulse_o equals the inverse of subseconds bit (SUB_W-1-n), giving 2^n Hz. pulse_o follows the live time with one cycle of latency.
- R9: Selector values above SUB_W-1 behave as SUB_W-1, so pulse_o toggles on every subsecond unit.
- R10: During and after reset, flag_o, irq_o and pulse_o are low, the arm bit is clear and both target words are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | SEC_W | Live seconds |
| sub_i | input | SUB_W | Live subseconds (binary fraction of a second) |
| tgt_sec_we_i | input | 1 | Write strobe for the target seconds word |
| tgt_sec_i | input | SEC_W | Target seconds write data |
| tgt_sub_we_i | input | 1 | Write strobe for the target subseconds word |
| tgt_sub_i | input | SUB_W | Target subseconds write data |
| arm_we_i | input | 1 | Write strobe for the interrupt arm bit |
| arm_i | input | 1 | Interrupt arm write data |
| stat_rd_i | input | 1 | Status read strobe, clears flag and interrupt |
| rate_sel_i | input | SEL_W | Pulse rate selector n (2^n Hz) |
| flag_o | output | 1 | Sticky target-reached status |
| irq_o | output | 1 | Target-reached interrupt |
| pulse_o | output | 1 | Rate pulse output |

## Verification
The bench builds the block with 3 seconds bits, 4 subseconds bits and a 3-bit selector. This shrinks the whole time space to 128 values, so every target value is swept against every live time, and the edge-only and one-shot behaviour is checked for each target. With this configuration every selector value, including the clamped ones, is also swept against every live time. The reset target of all ones, the read colliding with an event, and a single-word target write are reached directly.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

  // State of the one-shot interrupt path
  typedef struct packed {
    logic flag;
    logic irq;
  } ttc_stat_t;

  function automatic int unsigned ttc_max_sel(input int unsigned sub_w);
    return (sub_w > 0) ? sub_w - 1 : 0;
  endfunction

endpackage

// File: rtl/ttc_target_regs.sv
module ttc_target_regs #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_we_i,
  input  logic [SEC_W-1:0] sec_wdata_i,
  input  logic             sub_we_i,
  input  logic [SUB_W-1:0] sub_wdata_i,
  input  logic             arm_we_i,
  input  logic             arm_wdata_i,
  input  logic             arm_clr_i,
  output logic [SEC_W-1:0] tgt_sec_o,
  output logic [SUB_W-1:0] tgt_sub_o,
  output logic             arm_o
);

  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic             arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '1;
      sub_q <= '1;
    end else begin
      if (sec_we_i) sec_q <= sec_wdata_i;
      if (sub_we_i) sub_q <= sub_wdata_i;
    end
  end

  // software write wins over the one-shot clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= 1'b0;
    else if (arm_we_i)  arm_q <= arm_wdata_i;
    else if (arm_clr_i) arm_q <= 1'b0;
  end

  assign tgt_sec_o = sec_q;
  assign tgt_sub_o = sub_q;
  assign arm_o     = arm_q;

  p_sec_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_we_i |=> $stable(sec_q));
  p_sub_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_we_i |=> $stable(sub_q));
  p_arm_oneshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_clr_i && !arm_we_i) |=> !arm_q);

endmodule

// File: rtl/ttc_time_cmp.sv
module ttc_time_cmp
  import ttc_pkg::*;
#(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic [SUB_W-1:0] tgt_sub_i,
  input  logic             arm_i,
  input  logic             rd_i,
  output logic             arm_clr_o,
  output logic             flag_o,
  output logic             irq_o
);

  localparam int unsigned TW = SEC_W + SUB_W;

  logic [TW-1:0] live_w, tgt_w;
  logic          match, match_q, event_w;
  ttc_stat_t     stat_q, stat_d;

  assign live_w  = {sec_i, sub_i};
  assign tgt_w   = {tgt_sec_i, tgt_sub_i};
  assign match   = (live_w >= tgt_w);
  assign event_w = match && !match_q;

  always_comb begin
    stat_d = stat_q;
    if (rd_i) stat_d = '0;
    if (event_w) begin
      stat_d.flag = 1'b1;
      if (arm_i) stat_d.irq = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      match_q <= match;
      stat_q  <= stat_d;
    end
  end

  assign arm_clr_o = event_w && arm_i;
  assign flag_o    = stat_q.flag;
  assign irq_o     = stat_q.irq;

  p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_w |=> stat_q.flag);
  p_read_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !event_w) |=> (!stat_q.flag && !stat_q.irq));
  p_read_collide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && event_w) |=> stat_q.flag);
  p_irq_has_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q.irq |-> stat_q.flag);
  p_irq_unarmed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !stat_q.irq) |=> !stat_q.irq);

endmodule

// File: rtl/ttc_pulse_gen.sv
module ttc_pulse_gen
  import ttc_pkg::*;
#(
  parameter int unsigned SUB_W = 32,
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);

  localparam int unsigned MAX_SEL = ttc_max_sel(SUB_W);
  localparam int unsigned IDX_W   = (SUB_W > 1) ? $clog2(SUB_W) : 1;

  logic [IDX_W-1:0] tap;
  logic             pulse_q, started_q;

  // faster rate -> lower subseconds bit
  always_comb begin
    if (32'(sel_i) > MAX_SEL) tap = '0;
    else                      tap = IDX_W'(MAX_SEL - 32'(sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      pulse_q   <= ~sub_i[tap];
      started_q <= 1'b1;
    end
  end

  assign pulse_o = pulse_q;

  p_pulse_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $stable(sub_i) && $stable(sel_i)) |=> $stable(pulse_q));

endmodule

// File: rtl/ttc_event_pulse.sv
module ttc_event_pulse #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 32,
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic             tgt_sec_we_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic             tgt_sub_we_i,
  input  logic [SUB_W-1:0] tgt_sub_i,
  input  logic             arm_we_i,
  input  logic             arm_i,
  input  logic             stat_rd_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             pulse_o
);

  logic [SEC_W-1:0] tgt_sec;
  logic [SUB_W-1:0] tgt_sub;
  logic             arm, arm_clr;

  ttc_target_regs #(.SEC_W(SEC_W), .SUB_W(SUB_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sec_we_i    (tgt_sec_we_i),
    .sec_wdata_i (tgt_sec_i),
    .sub_we_i    (tgt_sub_we_i),
    .sub_wdata_i (tgt_sub_i),
    .arm_we_i    (arm_we_i),
    .arm_wdata_i (arm_i),
    .arm_clr_i   (arm_clr),
    .tgt_sec_o   (tgt_sec),
    .tgt_sub_o   (tgt_sub),
    .arm_o       (arm)
  );

  ttc_time_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) i_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_i     (sec_i),
    .sub_i     (sub_i),
    .tgt_sec_i (tgt_sec),
    .tgt_sub_i (tgt_sub),
    .arm_i     (arm),
    .rd_i      (stat_rd_i),
    .arm_clr_o (arm_clr),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
  );

  ttc_pulse_gen #(.SUB_W(SUB_W), .SEL_W(SEL_W)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sub_i   (sub_i),
    .sel_i   (rate_sel_i),
    .pulse_o (pulse_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!flag_o && !irq_o && !pulse_o));

endmodule

// File: tb/test_ttc_event_pulse.sv
module test_ttc_event_pulse;

  localparam int SEC_W = 3;
  localparam int SUB_W = 4;
  localparam int SEL_W = 3;
  localparam int TW    = SEC_W + SUB_W;
  localparam int NT    = 1 << TW;
  localparam int NSEL  = 1 << SEL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SEC_W-1:0] sec = '0;
  logic [SUB_W-1:0] sub = '0;
  logic             sec_we = 1'b0, sub_we = 1'b0;
  logic [SEC_W-1:0] tsec = '0;
  logic [SUB_W-1:0] tsub = '0;
  logic             arm_we = 1'b0, arm_d = 1'b0, rd = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic             flag, irq, pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ttc_event_pulse #(.SEC_W(SEC_W), .SUB_W(SUB_W), .SEL_W(SEL_W)) i_ttc_event_pulse (
    .clk_i(clk), .rst_ni(rst_n), .sec_i(sec), .sub_i(sub),
    .tgt_sec_we_i(sec_we), .tgt_sec_i(tsec), .tgt_sub_we_i(sub_we), .tgt_sub_i(tsub),
    .arm_we_i(arm_we), .arm_i(arm_d), .stat_rd_i(rd), .rate_sel_i(sel),
    .flag_o(flag), .irq_o(irq), .pulse_o(pulse)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic set_time(input int v);
    {sec, sub} = TW'(v);
  endtask

  task automatic wr_words(input bit ws, input bit wu, input int s, input int u);
    tsec = SEC_W'(s); tsub = SUB_W'(u);
    sec_we = ws; sub_we = wu;
    cyc();
    sec_we = 1'b0; sub_we = 1'b0;
  endtask

  task automatic wr_target(input int t);
    wr_words(1'b1, 1'b1, t >> SUB_W, t);
  endtask

  task automatic arm();
    arm_we = 1'b1; arm_d = 1'b1;
    cyc();
    arm_we = 1'b0; arm_d = 1'b0;
  endtask

  task automatic rd_clear();
    rd = 1'b1;
    cyc();
    rd = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) cyc();
    chk("R10 flag in reset", int'(flag), 0);
    chk("R10 irq in reset", int'(irq), 0);
    chk("R10 pulse in reset", int'(pulse), 0);
    rst_n = 1'b1;
    cyc(); cyc();
    chk("R10 flag after reset", int'(flag), 0);
    set_time(NT - 2); cyc();
    chk("R10 target all ones, below", int'(flag), 0);
    set_time(NT - 1); cyc();
    chk("R10 target all ones, reached", int'(flag), 1);
    chk("R10 arm clear at reset", int'(irq), 0);
    rd_clear();
    chk("R4 read clears flag", int'(flag), 0);

    // R2 R3 R6 full target x live-time sweep
    for (int t = 0; t < NT; t++) begin
      set_time(0);
      wr_target(t);
      cyc(); cyc();
      rd_clear();
      arm();
      for (int v = 0; v < NT; v++) begin
        set_time(v); cyc();
        chk("R2 R3 flag on compare", int'(flag), int'(t != 0 && v >= t));
        chk("R6 armed irq", int'(irq), int'(t != 0 && v >= t));
      end
      if (t != 0) begin
        rd_clear();
        chk("R4 flag cleared", int'(flag), 0);
        chk("R4 irq cleared", int'(irq), 0);
        set_time(0); cyc();
        set_time(t); cyc();
        chk("R3 second event flag", int'(flag), 1);
        chk("R6 one-shot arm", int'(irq), 0);
        rd_clear();
      end
    end

    // R5 read colliding with event
    set_time(0);
    wr_target(5);
    cyc(); cyc();
    rd_clear();
    arm();
    set_time(5); rd = 1'b1;
    cyc();
    rd = 1'b0;
    chk("R5 flag kept on collision", int'(flag), 1);
    chk("R5 irq kept on collision", int'(irq), 1);
    cyc();
    chk("R5 flag still set", int'(flag), 1);
    rd_clear();

    // R1 independent target words
    set_time(0);
    wr_words(1'b1, 1'b1, 2, 5);
    wr_words(1'b1, 1'b0, 6, 0);
    cyc(); cyc();
    rd_clear();
    arm();
    set_time((6 << SUB_W) | 4); cyc();
    chk("R1 sub word kept, below", int'(flag), 0);
    set_time((6 << SUB_W) | 5); cyc();
    chk("R1 sub word kept, reached", int'(flag), 1);
    rd_clear();

    // R7 R8 R9 pulse sweep
    for (int s = 0; s < NSEL; s++) begin
      for (int v = 0; v < NT; v++) begin
        int e, tap, ex;
        sel = SEL_W'(s);
        set_time(v);
        cyc();
        e   = (s > SUB_W - 1) ? SUB_W - 1 : s;
        tap = SUB_W - 1 - e;
        ex  = ((v >> tap) & 1) ? 0 : 1;
        if (s == 0)          chk("R7 pulse 1 Hz", int'(pulse), ex);
        else if (s < SUB_W)  chk("R8 pulse 2^n Hz", int'(pulse), ex);
        else                 chk("R9 pulse clamped", int'(pulse), ex);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule